// File: doc/BRIEF.md
# Flash Block Protection and Status Controller

This block is the command and protection core of an embedded flash controller. A host presents a command opcode together with an address, a data word and a protection-bypass bit. The block keeps one persistent write-protect flag per flash block and a status word with a ready bit, an erase-failure bit and a program-failure bit. It decides whether each program, erase or protect command may go ahead, then updates the cell array, the flags and the status. A read multiplexer returns array contents, the status word or a captured protect flag, depending on the last command seen.

Timed operations stay in progress for a programmable number of cycles. Commands that arrive during that time are dropped. The cell array is modelled as a small register file: an erase sets every word of a block to all ones, and a program can only clear bits. A protect flag can be cleared only by the protect command and set only by an erase that completes, so protection survives any number of bypass periods.

Top module: `flp_ctrl`

## Requirements
- R1: After reset, `seq_ready` is 1, `erase_err` and `prog_err` are 0, every array word reads all ones in array read mode, and every block's protect flag is 1 (writable).
- R2: A command is accepted only when `cmd_valid` is high and `seq_ready` is 1. An accepted program (op 4), block erase (op 5), erase-unprotected (op 6), protect-block (op 7) or read-flag (op 0) drops `seq_ready` for exactly `busy_cycles` cycles (a value of 0 counts as 1). Commands presented while `seq_ready` is 0 have no effect.
- R3: Program (op 4) on a writable block sets the word at `cmd_addr` to its old value AND `cmd_data`. If that result differs from `cmd_data`, `prog_err` becomes 1.
- R4: Protect-block (op 7) clears the flag of the block that `cmd_addr` selects. While `lock_override` is 0, a program aimed at a flagged block leaves the array unchanged and sets `prog_err`, and a block erase of a flagged block leaves it unchanged and sets `erase_err`.
- R5: A block erase (op 5) that goes ahead sets every word of the block to all ones and sets its protect flag to 1.
- R6: `lock_override` is sampled when a command is accepted. When it is 1, program and erase ignore the flags. The stored flags keep their values and apply again once the bit returns to 0.
- R7: Erase-unprotected (op 6) with `lock_override` at 0 erases only the blocks whose flag is 1 and leaves flagged blocks' data and flags unchanged. With `lock_override` at 1 it erases every block and sets every flag to 1.
- R8: After read-status (op 2), or after any accepted program, erase or protect command, a read at an even `rd_addr` returns the status word and a read at an odd `rd_addr` returns array data. Read-array (op 1) restores array data at every address.
- R9: When a read-flag command (op 0) completes, reads at any address return the flag of the addressed block in bit 0 with all other bits 0, until another read-mode change.
- R10: `erase_err` and `prog_err` stay set across later operations until clear-status (op 3), which clears both in the cycle it is accepted and does not change the read mode.
- R11: The status word has `seq_ready` in bit 7, `erase_err` in bit 5 and `prog_err` in bit 4. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | ADDR_W | Word address; the upper bits select the block |
| cmd_data | input | DATA_W | Program data |
| lock_override | input | 1 | 1 bypasses all protect flags without changing them |
| busy_cycles | input | BUSY_W | Duration of timed operations in cycles |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Array data, status word or protect flag |
| seq_ready | output | 1 | 1 when idle, 0 while a timed operation runs |
| erase_err | output | 1 | Sticky erase-failure flag |
| prog_err | output | 1 | Sticky program-failure flag |

## Verification
Programs are applied to fresh words, to words that already hold data whose bits the new pattern would have to raise, and to protected blocks with the bypass both off and on. Together these separate AND-only cell behaviour, the mismatch error and the protection veto. Erases are tried on single blocks and on a mix of protected and writable blocks, with and without bypass, which shows whether the flag filter and the flag restore act per block. Reads at even and odd addresses in each read mode separate the status path from the array path. A command sent during a busy period, followed by a flag read, shows whether it was dropped.

// File: rtl/flp_pkg.sv
// Shared opcodes, read-mode encoding and status-word bit positions for the
// flash protection controller. Assumes the data word is at least 8 bits wide.
package flp_pkg;

    typedef enum logic [2:0] {
        OP_READ_FLAG      = 3'd0,
        OP_READ_ARRAY     = 3'd1,
        OP_READ_STATUS    = 3'd2,
        OP_CLEAR_STATUS   = 3'd3,
        OP_PROGRAM        = 3'd4,
        OP_BLOCK_ERASE    = 3'd5,
        OP_ERASE_UNPROT   = 3'd6,
        OP_PROTECT_BLOCK  = 3'd7
    } flp_op_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_FLAG   = 2'd2
    } flp_rdmode_e;

    localparam int SR_READY_BIT = 7;
    localparam int SR_ERASE_BIT = 5;
    localparam int SR_PROG_BIT  = 4;

endpackage

// File: rtl/flp_array.sv
// Cell array model: NUM_BLOCKS blocks of WORDS_PER_BLOCK words. An erase mask
// bit sets the whole block to ones; a program ANDs data into one word.
// Erase takes priority over program. Assumes the total depth is a power of two.
module flp_array #(
    parameter  int NUM_BLOCKS      = 4,
    parameter  int WORDS_PER_BLOCK = 4,
    parameter  int DATA_W          = 8,
    localparam int DEPTH           = NUM_BLOCKS * WORDS_PER_BLOCK,
    localparam int ADDR_W          = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prog_en,
    input  logic [ADDR_W-1:0]     prog_addr,
    input  logic [DATA_W-1:0]     prog_data,
    input  logic [NUM_BLOCKS-1:0] erase_mask,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data,
    input  logic [ADDR_W-1:0]     chk_addr,
    output logic [DATA_W-1:0]     chk_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Cell update: reset to erased, then erase blocks or clear bits of one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
        end else begin
            for (int w = 0; w < DEPTH; w++) begin
                if (erase_mask[w / WORDS_PER_BLOCK])
                    mem[w] <= '1;
                else if (prog_en && prog_addr == ADDR_W'(w))
                    mem[w] <= mem[w] & prog_data;
            end
        end
    end

    // Two asynchronous read ports: host read and program verify.
    always_comb begin
        rd_data  = mem[rd_addr];
        chk_data = mem[chk_addr];
    end

endmodule

// File: rtl/flp_lock_bank.sv
// Persistent per-block protect flags. 1 = writable, 0 = protected.
// A set request (completed erase) wins over a clear request (protect command).
// Assumes NUM_BLOCKS >= 2.
module flp_lock_bank #(
    parameter  int NUM_BLOCKS = 4,
    localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BLOCKS-1:0] set_mask,
    input  logic                  clr_en,
    input  logic [BLK_W-1:0]      clr_blk,
    output logic [NUM_BLOCKS-1:0] flags
);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_flag
        // One flag: set by erase, cleared only by the protect command.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[b] <= 1'b1;
            else if (set_mask[b])
                flags[b] <= 1'b1;
            else if (clr_en && clr_blk == BLK_W'(b))
                flags[b] <= 1'b0;
        end
    end

endmodule

// File: rtl/flp_seq.sv
// Command sequencer: accepts commands while idle, latches timed commands and
// runs a busy counter, then applies the operation on the final busy cycle.
// Owns the sticky error bits and the read mode. The bypass bit is sampled at
// acceptance. Assumes the array and flag bank update on the same edge.
module flp_seq
    import flp_pkg::*;
#(
    parameter  int NUM_BLOCKS      = 4,
    parameter  int WORDS_PER_BLOCK = 4,
    parameter  int DATA_W          = 8,
    parameter  int BUSY_W          = 8,
    localparam int ADDR_W          = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK),
    localparam int WORD_AW         = $clog2(WORDS_PER_BLOCK),
    localparam int BLK_W           = $clog2(NUM_BLOCKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    input  logic [2:0]            cmd_op,
    input  logic [ADDR_W-1:0]     cmd_addr,
    input  logic [DATA_W-1:0]     cmd_data,
    input  logic                  lock_override,
    input  logic [BUSY_W-1:0]     busy_cycles,
    input  logic [NUM_BLOCKS-1:0] lock_flags,
    input  logic [DATA_W-1:0]     chk_data,
    output logic [ADDR_W-1:0]     chk_addr,
    output logic                  prog_en,
    output logic [ADDR_W-1:0]     prog_addr,
    output logic [DATA_W-1:0]     prog_data,
    output logic [NUM_BLOCKS-1:0] erase_mask,
    output logic                  lock_clr_en,
    output logic [BLK_W-1:0]      lock_clr_blk,
    output logic                  seq_ready,
    output logic                  erase_err,
    output logic                  prog_err,
    output flp_rdmode_e           rd_mode,
    output logic                  flag_cap
);

    flp_op_e           op_in;
    flp_op_e           op_q;
    logic              busy;
    logic [BUSY_W-1:0] cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              ovr_q;
    logic              accept;
    logic              finish;
    logic              timed;
    logic [BLK_W-1:0]  blk_q;
    logic              blocked;

    // Decode of the incoming command and of the running operation.
    always_comb begin
        op_in   = flp_op_e'(cmd_op);
        accept  = cmd_valid && !busy;
        finish  = busy && (cnt == BUSY_W'(1));
        timed   = (op_in == OP_PROGRAM) || (op_in == OP_BLOCK_ERASE) ||
                  (op_in == OP_ERASE_UNPROT) || (op_in == OP_PROTECT_BLOCK) ||
                  (op_in == OP_READ_FLAG);
        blk_q   = addr_q[ADDR_W-1:WORD_AW];
        blocked = !ovr_q && !lock_flags[blk_q];
    end

    // Busy counter and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            op_q   <= OP_READ_ARRAY;
            addr_q <= '0;
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else if (accept && timed) begin
            busy   <= 1'b1;
            cnt    <= (busy_cycles == '0) ? BUSY_W'(1) : busy_cycles;
            op_q   <= op_in;
            addr_q <= cmd_addr;
            data_q <= cmd_data;
            ovr_q  <= lock_override;
        end else if (finish) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt - BUSY_W'(1);
        end
    end

    // Update requests toward the array and the flag bank on the final cycle.
    always_comb begin
        prog_en     = 1'b0;
        erase_mask  = '0;
        lock_clr_en = 1'b0;
        if (finish) begin
            case (op_q)
                OP_PROGRAM:       prog_en = !blocked;
                OP_BLOCK_ERASE:   if (!blocked) erase_mask[blk_q] = 1'b1;
                OP_ERASE_UNPROT:  erase_mask = lock_flags | {NUM_BLOCKS{ovr_q}};
                OP_PROTECT_BLOCK: lock_clr_en = 1'b1;
                default:          ;
            endcase
        end
    end

    assign prog_addr    = addr_q;
    assign prog_data    = data_q;
    assign chk_addr     = addr_q;
    assign lock_clr_blk = blk_q;
    assign seq_ready    = !busy;

    // Sticky error bits: set on a vetoed or mismatching operation, cleared by command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_err <= 1'b0;
            prog_err  <= 1'b0;
        end else if (accept && op_in == OP_CLEAR_STATUS) begin
            erase_err <= 1'b0;
            prog_err  <= 1'b0;
        end else if (finish) begin
            if (op_q == OP_PROGRAM && (blocked || ((chk_data & data_q) != data_q)))
                prog_err <= 1'b1;
            if (op_q == OP_BLOCK_ERASE && blocked)
                erase_err <= 1'b1;
        end
    end

    // Read mode selection and capture of the flag for read-flag commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mode  <= RD_ARRAY;
            flag_cap <= 1'b1;
        end else if (accept) begin
            case (op_in)
                OP_READ_ARRAY:   rd_mode <= RD_ARRAY;
                OP_CLEAR_STATUS: rd_mode <= rd_mode;
                default:         rd_mode <= RD_STATUS;
            endcase
        end else if (finish && op_q == OP_READ_FLAG) begin
            rd_mode  <= RD_FLAG;
            flag_cap <= lock_flags[blk_q];
        end
    end

endmodule

// File: rtl/flp_ctrl.sv
// Top of the flash protection and status controller: ties the sequencer, the
// protect-flag bank and the cell array together and multiplexes host reads
// between array data, the status word and the captured protect flag.
// Assumes DATA_W >= 8 so that the status bit positions exist.
module flp_ctrl
    import flp_pkg::*;
#(
    parameter  int NUM_BLOCKS      = 4,
    parameter  int WORDS_PER_BLOCK = 4,
    parameter  int DATA_W          = 8,
    parameter  int BUSY_W          = 8,
    localparam int ADDR_W          = $clog2(NUM_BLOCKS * WORDS_PER_BLOCK),
    localparam int BLK_W           = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              lock_override,
    input  logic [BUSY_W-1:0] busy_cycles,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              seq_ready,
    output logic              erase_err,
    output logic              prog_err
);

    logic [NUM_BLOCKS-1:0] lock_flags;
    logic [NUM_BLOCKS-1:0] erase_mask;
    logic                  prog_en;
    logic [ADDR_W-1:0]     prog_addr;
    logic [DATA_W-1:0]     prog_data;
    logic [ADDR_W-1:0]     chk_addr;
    logic [DATA_W-1:0]     chk_data;
    logic [DATA_W-1:0]     arr_rd;
    logic                  lock_clr_en;
    logic [BLK_W-1:0]      lock_clr_blk;
    flp_rdmode_e           rd_mode;
    logic                  flag_cap;
    logic [DATA_W-1:0]     status_word;

    flp_seq #(
        .NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK),
        .DATA_W(DATA_W), .BUSY_W(BUSY_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .lock_override(lock_override),
        .busy_cycles(busy_cycles), .lock_flags(lock_flags),
        .chk_data(chk_data), .chk_addr(chk_addr),
        .prog_en(prog_en), .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_mask(erase_mask), .lock_clr_en(lock_clr_en),
        .lock_clr_blk(lock_clr_blk), .seq_ready(seq_ready),
        .erase_err(erase_err), .prog_err(prog_err),
        .rd_mode(rd_mode), .flag_cap(flag_cap)
    );

    flp_lock_bank #(.NUM_BLOCKS(NUM_BLOCKS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_mask(erase_mask),
        .clr_en(lock_clr_en), .clr_blk(lock_clr_blk), .flags(lock_flags)
    );

    flp_array #(
        .NUM_BLOCKS(NUM_BLOCKS), .WORDS_PER_BLOCK(WORDS_PER_BLOCK), .DATA_W(DATA_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_addr(prog_addr),
        .prog_data(prog_data), .erase_mask(erase_mask), .rd_addr(rd_addr),
        .rd_data(arr_rd), .chk_addr(chk_addr), .chk_data(chk_data)
    );

    // Read multiplexer: status on even addresses in status mode, flag in flag mode.
    always_comb begin
        status_word               = '0;
        status_word[SR_READY_BIT] = seq_ready;
        status_word[SR_ERASE_BIT] = erase_err;
        status_word[SR_PROG_BIT]  = prog_err;
        case (rd_mode)
            RD_STATUS: rd_data = rd_addr[0] ? arr_rd : status_word;
            RD_FLAG:   rd_data = {{(DATA_W-1){1'b0}}, flag_cap};
            default:   rd_data = arr_rd;
        endcase
    end

endmodule

// File: rtl/flp_ctrl_chk.sv
// Property checker for flp_ctrl, attached with bind. Watches the command
// strobe, the ready and error outputs, the status bit on reads and the flags.
module flp_ctrl_chk
    import flp_pkg::*;
#(
    parameter int NUM_BLOCKS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_valid,
    input logic [2:0]            cmd_op,
    input logic                  seq_ready,
    input logic                  erase_err,
    input logic                  prog_err,
    input logic                  rd_lsb,
    input logic                  rd_ready_bit,
    input logic [NUM_BLOCKS-1:0] lock_flags
);

    AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_ready) |-> $past(cmd_valid)); // R2

    AST_PROG_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_err) |-> $past(!seq_ready)); // R3

    AST_ERASE_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_err && !(cmd_valid && seq_ready && cmd_op == OP_CLEAR_STATUS)) |=> erase_err); // R10

    AST_PROG_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_err && !(cmd_valid && seq_ready && cmd_op == OP_CLEAR_STATUS)) |=> prog_err); // R10

    AST_BUSY_STATUS_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_ready && !rd_lsb) |-> !rd_ready_bit); // R8

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_flag_chk
        AST_FLAG_SET_BY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock_flags[b]) |-> $past(!seq_ready)); // R5
    end

endmodule

bind flp_ctrl flp_ctrl_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .seq_ready(seq_ready), .erase_err(erase_err), .prog_err(prog_err),
    .rd_lsb(rd_addr[0]), .rd_ready_bit(rd_data[flp_pkg::SR_READY_BIT]),
    .lock_flags(lock_flags)
);

// File: tb/flp_ctrl_bench.sv
module flp_ctrl_bench;

    localparam int AW = 4;
    localparam int DW = 8;
    localparam int BW = 8;

    localparam logic [2:0] C_RFLAG = 3'd0, C_RARR = 3'd1, C_RSTAT = 3'd2, C_CLR = 3'd3,
                           C_PROG = 3'd4, C_BERASE = 3'd5, C_EALL = 3'd6, C_PROT = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic          lock_override = 1'b0;
    logic [BW-1:0] busy_cycles = 8'd3;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          seq_ready;
    logic          erase_err;
    logic          prog_err;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    flp_ctrl u_flp_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .lock_override(lock_override),
        .busy_cycles(busy_cycles), .rd_addr(rd_addr), .rd_data(rd_data),
        .seq_ready(seq_ready), .erase_err(erase_err), .prog_err(prog_err)
    );

    task automatic expect_eq(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one command; return the number of cycles seq_ready stayed low.
    task automatic issue(input logic [2:0] op, input int addr, input int data, output int nbusy);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = AW'(addr); cmd_data = DW'(data);
        @(negedge clk);
        cmd_valid = 1'b0;
        nbusy = 0;
        while (!seq_ready && nbusy < 1000) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = AW'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic t_reset();
        int d, n;
        expect_eq("R1 ready", int'(seq_ready), 1);
        expect_eq("R1 erase_err", int'(erase_err), 0);
        expect_eq("R1 prog_err", int'(prog_err), 0);
        rd(0, d);  expect_eq("R1 word0 array mode", d, 8'hFF);
        rd(13, d); expect_eq("R1 word13", d, 8'hFF);
        issue(C_RFLAG, 8, 0, n);
        rd(8, d);  expect_eq("R1 flag of block2", d, 1);
        rd(3, d);  expect_eq("R9 flag at odd address", d, 1);
    endtask

    task automatic t_busy();
        int d, n;
        busy_cycles = 8'd5;
        issue(C_PROG, 0, 8'hFF, n);
        expect_eq("R2 busy length 5", n, 5);
        busy_cycles = 8'd0;
        issue(C_RFLAG, 0, 0, n);
        expect_eq("R2 busy length for zero", n, 1);
        busy_cycles = 8'd4;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = C_PROG; cmd_addr = 4'd0; cmd_data = 8'hFF;
        @(negedge clk);
        cmd_op = C_PROT; cmd_addr = 4'd12;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!seq_ready) @(negedge clk);
        busy_cycles = 8'd3;
        issue(C_RFLAG, 12, 0, n);
        rd(12, d); expect_eq("R2 command during busy dropped", d, 1);
    endtask

    task automatic t_program();
        int d, n;
        issue(C_PROG, 1, 8'h3C, n);
        rd(0, d); expect_eq("R8 R11 status at even address", d, 8'h80);
        rd(1, d); expect_eq("R8 array at odd address", d, 8'h3C);
        issue(C_RARR, 0, 0, n);
        rd(0, d); expect_eq("R8 read-array restores", d, 8'hFF);
        issue(C_PROG, 1, 8'hC3, n);
        rd(2, d); expect_eq("R3 R11 mismatch status", d, 8'h90);
        issue(C_RARR, 0, 0, n);
        rd(1, d); expect_eq("R3 AND result", d, 8'h00);
        issue(C_CLR, 0, 0, n);
        expect_eq("R10 clear prog_err", int'(prog_err), 0);
        rd(1, d); expect_eq("R10 clear keeps array mode", d, 8'h00);
        issue(C_RSTAT, 0, 0, n);
        rd(2, d); expect_eq("R10 status after clear", d, 8'h80);
    endtask

    task automatic t_protect();
        int d, n;
        issue(C_PROT, 4, 0, n);
        issue(C_RFLAG, 5, 0, n);
        rd(4, d); expect_eq("R4 flag cleared", d, 0);
        issue(C_RFLAG, 0, 0, n);
        rd(7, d); expect_eq("R9 other block flag", d, 1);
        issue(C_PROG, 4, 8'h00, n);
        expect_eq("R4 program vetoed err", int'(prog_err), 1);
        issue(C_BERASE, 4, 0, n);
        expect_eq("R4 erase vetoed err", int'(erase_err), 1);
        rd(0, d); expect_eq("R4 R11 both errors", d, 8'hB0);
        issue(C_PROG, 2, 8'hF0, n);
        rd(0, d); expect_eq("R10 errors sticky", d, 8'hB0);
        issue(C_RARR, 0, 0, n);
        rd(4, d); expect_eq("R4 protected word unchanged", d, 8'hFF);
        rd(2, d); expect_eq("R3 fresh program", d, 8'hF0);
        issue(C_CLR, 0, 0, n);
        expect_eq("R10 clear erase_err", int'(erase_err), 0);
    endtask

    task automatic t_override();
        int d, n;
        lock_override = 1'b1;
        issue(C_PROG, 5, 8'h55, n);
        expect_eq("R6 bypass program ok", int'(prog_err), 0);
        issue(C_RARR, 0, 0, n);
        rd(5, d); expect_eq("R6 bypass program data", d, 8'h55);
        issue(C_RFLAG, 4, 0, n);
        rd(4, d); expect_eq("R6 flag retained", d, 0);
        lock_override = 1'b0;
        issue(C_PROG, 6, 8'h11, n);
        expect_eq("R6 protection returns", int'(prog_err), 1);
        issue(C_RARR, 0, 0, n);
        rd(6, d); expect_eq("R6 word untouched", d, 8'hFF);
        issue(C_CLR, 0, 0, n);
        lock_override = 1'b1;
        issue(C_BERASE, 4, 0, n);
        lock_override = 1'b0;
        expect_eq("R6 bypass erase ok", int'(erase_err), 0);
        issue(C_RARR, 0, 0, n);
        rd(5, d); expect_eq("R5 erased word", d, 8'hFF);
        issue(C_RFLAG, 4, 0, n);
        rd(4, d); expect_eq("R5 flag restored", d, 1);
    endtask

    task automatic t_erase_all();
        int d, n;
        issue(C_PROG, 8, 8'h34, n);
        issue(C_PROG, 12, 8'h0F, n);
        issue(C_PROT, 8, 0, n);
        issue(C_EALL, 0, 0, n);
        expect_eq("R7 no errors", int'(erase_err | prog_err), 0);
        issue(C_RARR, 0, 0, n);
        rd(1, d);  expect_eq("R7 writable block0 erased", d, 8'hFF);
        rd(2, d);  expect_eq("R7 writable block0 word2", d, 8'hFF);
        rd(12, d); expect_eq("R7 writable block3 erased", d, 8'hFF);
        rd(8, d);  expect_eq("R7 protected block kept", d, 8'h34);
        issue(C_RFLAG, 8, 0, n);
        rd(8, d);  expect_eq("R7 protected flag kept", d, 0);
        lock_override = 1'b1;
        issue(C_EALL, 0, 0, n);
        lock_override = 1'b0;
        issue(C_RARR, 0, 0, n);
        rd(8, d);  expect_eq("R7 bypass erase all", d, 8'hFF);
        issue(C_RFLAG, 8, 0, n);
        rd(8, d);  expect_eq("R7 bypass sets flag", d, 1);
    endtask

    task automatic t_block_erase();
        int d, n;
        issue(C_PROG, 13, 8'hA5, n);
        issue(C_BERASE, 12, 0, n);
        issue(C_RARR, 0, 0, n);
        rd(13, d); expect_eq("R5 block erase", d, 8'hFF);
        rd(1, d);  expect_eq("R5 other block untouched", d, 8'hFF);
    endtask

    initial begin
        #(200000 * 20);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_busy();
        t_program();
        t_protect();
        t_override();
        t_erase_all();
        t_block_erase();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule